// File: doc/BRIEF.md
# Half-Wave Sine/Cosine Lookup Generator

This block turns a 12-bit phase angle into an 18-bit signed sine-family value. It keeps only one table: the positive half-wave of sine, sampled at 2048 evenly spaced points over 0 to π. Each word is an unsigned magnitude. A 2-bit function code is added to the two top bits of the angle, so one table serves sine, cosine, negated sine and negated cosine. After that offset, the top bit of the shifted angle decides whether the table word is passed through or two's-complemented.

The block is a fixed six-register pipeline with no stalls. One request may enter on every clock. Each request carries a valid flag that travels through the same stages as the data. The sign decision is delayed by registers so that it meets the magnitude as the magnitude leaves the registered table read. A rotation or coordinate-transform datapath uses the block as its trigonometric source. It issues angle and function code pairs back to back and collects results a fixed number of cycles later.

Top module: `sincos_halfwave_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted request emerges, `out_valid` is 0 and `out_value` is 0.
- R2: With `in_sel` = 0, `out_value` equals round(sin(a·π/2048)·131071) for angle a, with rounding symmetric about zero.
- R3: With `in_sel` = 1, the angle is advanced by 1024 codes (π/2), and `out_value` equals the cosine of a at the same scale.
- R4: With `in_sel` = 2, the angle is advanced by 2048 codes (π), and `out_value` equals the negated sine of a.
- R5: With `in_sel` = 3, the angle is advanced by 3072 codes, and `out_value` equals the negated cosine of a. The sum of the function code and angle bits [11:10] wraps modulo 4.
- R6: A request sampled at a rising edge produces its result at the sixth rising edge, counting the sampling edge. A new request is accepted on every edge, and back-to-back results appear on consecutive cycles.
- R7: `out_valid` reproduces the `in_valid` sequence delayed by six edges. A cycle with `in_valid` low produces no valid output.
- R8: While `out_valid` is 0, `out_value` keeps the last valid result, or 0 if there has been none since reset.
- R9: The table peak is reached exactly. Sine of 1024 gives 131071, sine of 3072 gives −131071, sine of 0 gives 0, and cosine of 0 gives 131071. No valid output is ever −131072.
- R10: If bit 11 of the angle after the offset is 1, the result is the two's complement of the word produced for the angle 2048 codes lower, so the result is ≤ 0. Otherwise the result is ≥ 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request qualifier |
| in_angle | input | 12 | Phase angle, 4096 codes per full turn |
| in_sel | input | 2 | Function code: 0 sin, 1 cos, 2 −sin, 3 −cos |
| out_valid | output | 1 | Result qualifier, six edges after the request |
| out_value | output | 18 | Signed result, two's complement |

## Verification
A sign register that slips by one stage against the table read would pair each magnitude with the sign of a neighbouring request. Any back-to-back sweep that crosses a half-turn boundary shows this within six cycles, as a result with the wrong sign. A wrong phase sum or a wrong table word corrupts the value of one specific angle and function pair. So the bench sweeps every angle under every function code and compares each result against a sine computed directly from the full angle. A broken valid or hold path shows up either in the `out_valid` pattern or as a changed `out_value` during idle cycles of a gapped stream.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  typedef enum logic [1:0] {
    FN_SIN  = 2'd0,
    FN_COS  = 2'd1,
    FN_NSIN = 2'd2,
    FN_NCOS = 2'd3
  } fn_sel_e;

  // Magnitude of one half-wave sample: round(sin(k*pi/2^addr_w) * (2^(data_w-1)-1))
  function automatic int halfwave_word(input int k, input int addr_w, input int data_w);
    real pi_c;
    real amp;
    real x;
    pi_c = 3.14159265358979323846;
    amp  = real'((1 << (data_w - 1)) - 1);
    x    = $sin(real'(k) * pi_c / real'(1 << addr_w)) * amp;
    return $rtoi($floor(x + 0.5));
  endfunction

  // Quadrant rotation: function code added to the two top angle bits, wrapping
  function automatic logic [1:0] rotate_quadrant(input logic [1:0] top, input logic [1:0] sel);
    return top + sel;
  endfunction

endpackage

// File: rtl/sc_delay.sv
module sc_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] taps [DEPTH+1];

  assign taps[0] = d;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps[i+1] <= '0;
        else        taps[i+1] <= taps[i];
      end
    end
  endgenerate

  assign q = taps[DEPTH];

endmodule

// File: rtl/sc_phase_stage.sv
module sc_phase_stage
  import sincos_pkg::*;
#(
  parameter int ANGLE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ANGLE_W-1:0] in_angle,
  input  logic [1:0]         in_sel,
  output logic               rd_valid,
  output logic [ANGLE_W-2:0] rd_addr,
  output logic               rd_negate
);

  // Stage 1: capture
  logic               cap_valid;
  logic [ANGLE_W-1:0] cap_angle;
  logic [1:0]         cap_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_angle <= '0;
      cap_sel   <= '0;
    end else begin
      cap_valid <= in_valid;
      cap_angle <= in_angle;
      cap_sel   <= in_sel;
    end
  end

  // Stage 2: quadrant offset
  logic [1:0]         quad_rot;
  logic [ANGLE_W-1:0] shifted;

  assign quad_rot = rotate_quadrant(cap_angle[ANGLE_W-1 -: 2], cap_sel);
  assign shifted  = {quad_rot, cap_angle[ANGLE_W-3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_addr   <= '0;
      rd_negate <= 1'b0;
    end else begin
      rd_valid  <= cap_valid;
      rd_addr   <= shifted[ANGLE_W-2:0];
      rd_negate <= shifted[ANGLE_W-1];
    end
  end

endmodule

// File: rtl/sc_halfwave_rom.sv
module sc_halfwave_rom
  import sincos_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 18,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = DATA_W'(halfwave_word(k, ADDR_W, DATA_W));
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[addr];
  end

  generate
    if (OUT_REG) begin : g_oreg
      logic [DATA_W-1:0] oreg_q;
      always_ff @(posedge clk) begin
        oreg_q <= rd_q;
      end
      assign q = oreg_q;
    end else begin : g_noreg
      assign q = rd_q;
    end
  endgenerate

endmodule

// File: rtl/sc_sign_stage.sv
module sc_sign_stage #(
  parameter int DATA_W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mag_valid,
  input  logic [DATA_W-1:0]        mag,
  input  logic                     negate,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_value
);

  localparam int AMP = (1 << (DATA_W - 1)) - 1;

  // Stage 5: conditional two's complement
  logic                     cmp_valid;
  logic signed [DATA_W-1:0] cmp_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_valid <= 1'b0;
      cmp_value <= '0;
    end else begin
      cmp_valid <= mag_valid;
      cmp_value <= negate ? -$signed(mag) : $signed(mag);
    end
  end

  // Stage 6: output register, loads only on valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= cmp_valid;
      if (cmp_valid) out_value <= cmp_value;
    end
  end

  // R8: idle cycles leave the result untouched
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_value));

  // R9: results stay inside the symmetric amplitude
  assert_amp_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_value >= -AMP) && (out_value <= AMP));

endmodule

// File: rtl/sincos_halfwave_gen.sv
module sincos_halfwave_gen
  import sincos_pkg::*;
#(
  parameter int ANGLE_W = 12,
  parameter int DATA_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [ANGLE_W-1:0]       in_angle,
  input  logic [1:0]               in_sel,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_value
);

  localparam int  ADDR_W   = ANGLE_W - 1;
  localparam bit  ROM_OREG = 1'b1;
  localparam int  ROM_LAT  = ROM_OREG ? 2 : 1;
  localparam int  PIPE_LAT = 2 + ROM_LAT + 2;

  logic              rd_valid;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_negate;
  logic [DATA_W-1:0] rom_word;
  logic [1:0]        side_q;

  sc_phase_stage #(.ANGLE_W(ANGLE_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_angle  (in_angle),
    .in_sel    (in_sel),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .rd_negate (rd_negate)
  );

  sc_halfwave_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_REG(ROM_OREG)) u_rom (
    .clk  (clk),
    .addr (rd_addr),
    .q    (rom_word)
  );

  // Sign and valid follow the table read latency
  sc_delay #(.W(2), .DEPTH(ROM_LAT)) u_side (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rd_valid, rd_negate}),
    .q     (side_q)
  );

  sc_sign_stage #(.DATA_W(DATA_W)) u_sign (
    .clk       (clk),
    .rst_n     (rst_n),
    .mag_valid (side_q[1]),
    .mag       (rom_word),
    .negate    (side_q[0]),
    .out_valid (out_valid),
    .out_value (out_value)
  );

  // Observation wires for the checks below
  logic [1:0] req_quadrant;
  logic       req_upper_half;
  logic [2:0] cycles_since_rst;
  logic       history_full;

  assign req_quadrant   = in_angle[ANGLE_W-1 -: 2] + in_sel;
  assign req_upper_half = req_quadrant[1];
  assign history_full   = (cycles_since_rst >= 3'(PIPE_LAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cycles_since_rst <= '0;
    else if (cycles_since_rst != 3'd7) cycles_since_rst <= cycles_since_rst + 3'd1;
  end

  // R7: valid pattern reproduced after the fixed latency
  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    history_full |-> (out_valid == $past(in_valid, PIPE_LAT)));

  // R10: sign of each result matches the half-turn of its own request
  assert_sign_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (history_full && out_valid) |->
      ($past(req_upper_half, PIPE_LAT) ? (out_value <= 0) : (out_value >= 0)));

endmodule

// File: tb/tb_sincos_halfwave_gen.sv
`timescale 1ns/1ps
module tb_sincos_halfwave_gen;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [11:0]        in_angle = '0;
  logic [1:0]         in_sel = '0;
  logic               out_valid;
  logic signed [17:0] out_value;

  always #10 clk = ~clk;

  sincos_halfwave_gen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_angle  (in_angle),
    .in_sel    (in_sel),
    .out_valid (out_valid),
    .out_value (out_value)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit    hv [1:6];
  int    he [1:6];
  string hl [1:6];
  int    last_res = 0;

  function automatic int exp_val(input int a, input int s);
    int  p;
    real r;
    p = (a + s * 1024) % 4096;
    r = $sin(real'(p) * 3.14159265358979323846 / 2048.0) * 131071.0;
    if (r >= 0.0) return $rtoi($floor(r + 0.5));
    else          return -$rtoi($floor(-r + 0.5));
  endfunction

  function automatic string sel_label(input int s);
    case (s)
      0:       return "R2 sin";
      1:       return "R3 cos";
      2:       return "R4 -sin";
      default: return "R5 -cos";
    endcase
  endfunction

  task automatic chk(input bit ok, input string lbl, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", lbl, act, expv);
    end
  endtask

  // One cycle: check the result due now, then drive the next request.
  task automatic step(input bit v, input int a, input int s, input string lbl);
    int act;
    act = int'(out_value);
    if (hv[6]) begin
      chk(out_valid === 1'b1, {hl[6], " valid (R6/R7)"}, int'(out_valid), 1);
      chk(act == he[6], hl[6], act, he[6]);
      last_res = he[6];
    end else begin
      chk(out_valid === 1'b0, "R7 no valid for idle slot", int'(out_valid), 0);
      chk(act == last_res, "R8 hold while idle", act, last_res);
    end
    for (int k = 6; k > 1; k--) begin
      hv[k] = hv[k-1];
      he[k] = he[k-1];
      hl[k] = hl[k-1];
    end
    hv[1]    = v;
    he[1]    = v ? exp_val(a, s) : 0;
    hl[1]    = lbl;
    in_valid = v;
    in_angle = 12'(a);
    in_sel   = 2'(s);
    @(negedge clk);
  endtask

  initial begin
    for (int k = 1; k <= 6; k++) begin
      hv[k] = 1'b0;
      he[k] = 0;
      hl[k] = "";
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(out_valid === 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(int'(out_value) == 0, "R1 value in reset", int'(out_value), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle after reset
    for (int i = 0; i < 8; i++) step(1'b0, 0, 0, "R1");

    // Directed boundary cases
    step(1'b1, 0,    0, "R9 sin(0)");
    step(1'b1, 1024, 0, "R9 sin peak");
    step(1'b1, 3072, 0, "R9 sin trough");
    step(1'b1, 0,    1, "R9 cos(0)");
    step(1'b1, 2048, 1, "R9 cos(pi)");
    step(1'b1, 1,    0, "R10 low half");
    step(1'b1, 2049, 0, "R10 high half");
    step(1'b1, 4095, 3, "R5 wrap");
    step(1'b1, 3071, 2, "R10 wrap edge");

    // Exhaustive back-to-back sweep, all functions (R2..R5, R6 throughput)
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4096; a++)
        step(1'b1, a, s, sel_label(s));

    // Gapped stream (R7, R8)
    for (int i = 0; i < 600; i++)
      step((i % 3) != 1, (i * 37 + 5) % 4096, i % 4, "R7 gapped");

    for (int i = 0; i < 8; i++) step(1'b0, 0, 0, "R8 flush");

    // R6: explicit latency count for an isolated request
    begin
      int seen;
      seen = 0;
      in_valid = 1'b1;
      in_angle = 12'd1024;
      in_sel   = 2'd0;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 1; k <= 8; k++) begin
        if (out_valid === 1'b1 && seen == 0) seen = k;
        if (k < 8) @(negedge clk);
      end
      chk(seen == 6, "R6 latency in cycles", seen, 6);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule